// File: doc/BRIEF.md
# Modified Miller Frame Decoder

This block turns the reader-to-card bitstream of a proximity card link into framed bytes. The sampling front end hands it one nibble of four pause samples per bit period. The newest sample sits in bit 0 and the oldest in bit 3. A sample of 1 means that the carrier was paused. The decoder splits each aligned period into a first half and a second half, and classifies the period as sequence X, Y or Z. It finds the start of a frame and the sample alignment of that frame, and it enforces the rules on which sequence may follow which. It resets itself when a rule is broken. It collects the decoded bits into bytes, and each byte carries its own parity bit.

At the end of a frame the block raises a one-cycle done strobe and holds the following on its outputs until the next frame starts: the bytes, the parity bits, the byte count, the bit count of a trailing partial byte, a short-frame flag, and the sample timestamps of the frame. A busy output is high while a frame is being decoded. A neighbouring decoder for the card-to-reader direction can use it as an inhibit.

Top module: `miller_frame_decoder`

## Requirements
- R1: A half of a period counts as paused when either of its two samples is 1. The first half is bits [3:2] of the aligned period and the second half is bits [1:0]. A pause in the first half only is sequence Z and decodes as logic 0. A pause in the second half only is sequence X and decodes as logic 1.
- R2: While unsynchronised, each accepted nibble forms an 8-bit window with the previous nibble in the upper four bits. The decoder tests the offsets s = 3, 2, 1, 0 in that order, taking window bits [s+3:s] as the period. The first offset that shows a Z is start of communication, and later periods are read at that same offset. From the next cycle, busy is high until the decoder is unsynchronised again.
- R3: A period with a pause in both halves pulses err_reset for one cycle. The decoder returns to unsynchronised and frame_len becomes 0.
- R4: A Z that directly follows an X is a violation and is handled as in R3.
- R5: A Y (no pause in either half) after an X decodes as logic 0. A Y after a Z or a Y is end of communication. The logic 0 just before that Y is discarded, frame_done pulses for one cycle, and busy is low in that cycle.
- R6: A Y directly after the start-of-communication period is a violation and is handled as in R3.
- R7: On air, each byte is 8 data bits, least significant first, followed by its parity bit. Byte k appears at frame_data[8k+7:8k] and its parity at frame_par[MAX_BYTES-1-k]. A trailing partial byte holds its bits right-aligned with parity 0, and last_bits gives its length (1 to 8). When the frame ends on a byte boundary, last_bits is 0. Unused bytes and parity bits are 0.
- R8: short_frame is 1 exactly when the frame is a single partial byte of 7 bits.
- R9: Each accepted nibble advances a sample counter by 4, starting from 0 at reset. start_time is the index of the first sample of the start period. end_time is start_time + 4 × (kept data bits + 1).
- R10: frame_len never exceeds MAX_BYTES. Bytes beyond that are dropped.
- R11: A cycle with nib_valid low has no effect on decoding, timing or outputs.
- R12: After reset, busy, frame_done, err_reset, frame_len, last_bits and short_frame are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nib_valid | input | 1 | nib holds a new bit period of samples |
| nib | input | 4 | Four pause samples, oldest in bit 3 |
| busy | output | 1 | Frame being decoded |
| frame_done | output | 1 | One-cycle end-of-frame strobe |
| err_reset | output | 1 | One-cycle strobe on a sequence violation |
| frame_data | output | 8*MAX_BYTES | Decoded bytes, byte k at [8k+7:8k] |
| frame_par | output | MAX_BYTES | Parity bits, byte 0 at the MSB |
| frame_len | output | $clog2(MAX_BYTES+1) | Bytes in the frame, partial byte included |
| last_bits | output | 4 | Bits in a trailing partial byte, 0 if none |
| short_frame | output | 1 | Single 7-bit frame |
| start_time | output | TW | Sample index of the frame start |
| end_time | output | TW | Sample index after the last data bit |

## Verification
The hardest states to reach from the ports have two sources. One is a frame whose start period straddles two nibbles. The other is a frame whose discarded end bit would have opened a new byte, so that the last full byte must already be stored together with its parity. The bench produces both by delaying whole sample streams by one to three samples. It also sends frames of exactly 9, 18, 16 and 45 bits, so the end of communication falls on a byte boundary, inside a byte, and after the byte store is full. Violations are injected right after an X and right after the start period. One stream also has invalid cycles carrying all-ones garbage placed between its nibbles.

// File: rtl/miller_dec_pkg.sv
// Shared types for the pause-code frame decoder.
// Assumes four samples per bit period, with the oldest sample in the MSB.
package miller_dec_pkg;

    typedef enum logic [1:0] {
        SYM_Y   = 2'd0,
        SYM_X   = 2'd1,
        SYM_Z   = 2'd2,
        SYM_BAD = 2'd3
    } sym_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SOC    = 3'd1,
        ST_LAST_X = 3'd2,
        ST_LAST_Y = 3'd3,
        ST_LAST_Z = 3'd4
    } dec_st_e;

    // Classify one aligned period: a half is paused if either of its samples is set.
    function automatic sym_e classify_period(input logic [3:0] p);
        logic first_h;
        logic second_h;
        first_h  = |p[3:2];
        second_h = |p[1:0];
        case ({first_h, second_h})
            2'b10:   return SYM_Z;
            2'b01:   return SYM_X;
            2'b00:   return SYM_Y;
            default: return SYM_BAD;
        endcase
    endfunction

endpackage

// File: rtl/miller_sym_slicer.sv
// Cuts the four candidate periods out of a two-nibble window and classifies them.
// Reports the symbol at the locked alignment and, for start detection, the
// first offset (oldest first) that holds a Z. Purely combinational.
module miller_sym_slicer
    import miller_dec_pkg::*;
#(
    parameter int SPP = 4
) (
    input  logic [2*SPP-1:0]       win,
    input  logic [$clog2(SPP)-1:0] align,
    output sym_e                   sym,
    output logic                   soc_hit,
    output logic [$clog2(SPP)-1:0] soc_off
);
    localparam int AW = $clog2(SPP);

    sym_e cand [SPP];

    // One classifier per possible alignment offset.
    for (genvar g = 0; g < SPP; g++) begin : g_cand
        assign cand[g] = classify_period(win[g+SPP-1 -: SPP]);
    end

    // Symbol at the locked offset.
    assign sym = cand[align];

    // Priority search for a start period, oldest offset first.
    always_comb begin
        soc_hit = 1'b0;
        soc_off = '0;
        for (int i = SPP - 1; i >= 0; i--) begin
            if (!soc_hit && cand[i] == SYM_Z) begin
                soc_hit = 1'b1;
                soc_off = AW'(i);
            end
        end
    end
endmodule

// File: rtl/miller_byte_asm.sv
// Collects decoded bits into 9-bit groups (8 data bits, LSB first, then parity).
// A full group is stored only when the next bit arrives, so the end-of-frame
// step can discard the final bit by undoing one shift. Assumes clr, fin and push
// are never raised together (the caller gives clr priority).
module miller_byte_asm #(
    parameter int MAX_BYTES = 4,
    parameter int LW        = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   push,
    input  logic                   bit_in,
    input  logic                   fin,
    output logic [8*MAX_BYTES-1:0] frame_data,
    output logic [MAX_BYTES-1:0]   frame_par,
    output logic [LW-1:0]          frame_len,
    output logic [3:0]             last_bits,
    output logic                   short_frame
);
    logic [8:0] sr;
    logic [3:0] cnt;
    logic [3:0] cnt_m1;
    logic [8:0] sr_back;
    logic [8:0] part_sh;
    logic       room;

    // Undo of the most recent shift and right alignment of a partial byte.
    always_comb begin
        cnt_m1  = (cnt == 4'd0) ? 4'd0 : cnt - 4'd1;
        sr_back = {sr[7:0], 1'b0};
        part_sh = sr_back >> (4'd9 - cnt_m1);
        room    = (frame_len < LW'(MAX_BYTES));
    end

    // Shift, store and end-of-frame bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sr          <= '0;
            cnt         <= '0;
            frame_data  <= '0;
            frame_par   <= '0;
            frame_len   <= '0;
            last_bits   <= '0;
            short_frame <= 1'b0;
        end else if (fin) begin
            sr          <= '0;
            cnt         <= '0;
            last_bits   <= cnt_m1;
            short_frame <= (frame_len == '0) && (cnt_m1 == 4'd7);
            if (cnt_m1 != 4'd0 && room) begin
                for (int k = 0; k < MAX_BYTES; k++) begin
                    if (LW'(k) == frame_len) frame_data[k*8 +: 8] <= part_sh[7:0];
                end
                frame_len <= frame_len + 1'b1;
            end
        end else if (push) begin
            if (cnt == 4'd9) begin
                if (room) begin
                    for (int k = 0; k < MAX_BYTES; k++) begin
                        if (LW'(k) == frame_len) begin
                            frame_data[k*8 +: 8]     <= sr[7:0];
                            frame_par[MAX_BYTES-1-k] <= sr[8];
                        end
                    end
                    frame_len <= frame_len + 1'b1;
                end
                sr  <= {bit_in, 8'h00};
                cnt <= 4'd1;
            end else begin
                sr  <= {bit_in, sr[8:1]};
                cnt <= cnt + 4'd1;
            end
        end
    end

    // R8
    short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_frame |-> (frame_len == LW'(1) && last_bits == 4'd7));

    // R10
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_len <= LW'(MAX_BYTES));

    // R7
    last_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_bits <= 4'd8);
endmodule

// File: rtl/miller_frame_decoder.sv
// Pause-code frame decoder for the reader-to-card direction.
// Takes one 4-sample nibble per accepted bit period. Locks onto the sample
// alignment at start of communication, applies the sequence rules, and hands
// the decoded bits to the byte assembler. Assumes idle (all-zero) samples
// between frames.
module miller_frame_decoder
    import miller_dec_pkg::*;
#(
    parameter int MAX_BYTES = 4,
    parameter int TW        = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             nib_valid,
    input  logic [3:0]                       nib,
    output logic                             busy,
    output logic                             frame_done,
    output logic                             err_reset,
    output logic [8*MAX_BYTES-1:0]           frame_data,
    output logic [MAX_BYTES-1:0]             frame_par,
    output logic [$clog2(MAX_BYTES+1)-1:0]   frame_len,
    output logic [3:0]                       last_bits,
    output logic                             short_frame,
    output logic [TW-1:0]                    start_time,
    output logic [TW-1:0]                    end_time
);
    localparam int SPP = 4;
    localparam int AW  = $clog2(SPP);
    localparam int LW  = $clog2(MAX_BYTES + 1);

    dec_st_e        st, st_n;
    logic [3:0]     prev_nib;
    logic [AW-1:0]  align;
    logic [TW-1:0]  smp_cnt;
    sym_e           sym;
    logic           soc_hit;
    logic [AW-1:0]  soc_off;
    logic           asm_clr, asm_push, asm_bit, asm_fin;
    logic           soc_take, done_n, err_n;

    miller_sym_slicer #(.SPP(SPP)) u_slicer (
        .win     ({prev_nib, nib}),
        .align   (align),
        .sym     (sym),
        .soc_hit (soc_hit),
        .soc_off (soc_off)
    );

    miller_byte_asm #(.MAX_BYTES(MAX_BYTES), .LW(LW)) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (asm_clr),
        .push        (asm_push),
        .bit_in      (asm_bit),
        .fin         (asm_fin),
        .frame_data  (frame_data),
        .frame_par   (frame_par),
        .frame_len   (frame_len),
        .last_bits   (last_bits),
        .short_frame (short_frame)
    );

    // Sequence rules: next state and assembler commands for one accepted period.
    always_comb begin
        st_n     = st;
        asm_clr  = 1'b0;
        asm_push = 1'b0;
        asm_bit  = 1'b0;
        asm_fin  = 1'b0;
        soc_take = 1'b0;
        done_n   = 1'b0;
        err_n    = 1'b0;
        if (nib_valid) begin
            if (st == ST_IDLE) begin
                if (soc_hit) begin
                    st_n     = ST_SOC;
                    asm_clr  = 1'b1;
                    soc_take = 1'b1;
                end
            end else begin
                case (sym)
                    SYM_X: begin
                        asm_push = 1'b1;
                        asm_bit  = 1'b1;
                        st_n     = ST_LAST_X;
                    end
                    SYM_Z: begin
                        if (st == ST_LAST_X) begin
                            err_n = 1'b1;
                        end else begin
                            asm_push = 1'b1;
                            st_n     = ST_LAST_Z;
                        end
                    end
                    SYM_Y: begin
                        if (st == ST_SOC) begin
                            err_n = 1'b1;
                        end else if (st == ST_LAST_X) begin
                            asm_push = 1'b1;
                            st_n     = ST_LAST_Y;
                        end else begin
                            asm_fin = 1'b1;
                            done_n  = 1'b1;
                            st_n    = ST_IDLE;
                        end
                    end
                    default: err_n = 1'b1;
                endcase
                if (err_n) begin
                    asm_clr = 1'b1;
                    st_n    = ST_IDLE;
                end
            end
        end
    end

    // State, window history, sample clock and frame timestamps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            prev_nib   <= '0;
            align      <= '0;
            smp_cnt    <= '0;
            start_time <= '0;
            end_time   <= '0;
            frame_done <= 1'b0;
            err_reset  <= 1'b0;
        end else begin
            st         <= st_n;
            frame_done <= done_n;
            err_reset  <= err_n;
            if (nib_valid) begin
                prev_nib <= nib;
                smp_cnt  <= smp_cnt + TW'(SPP);
            end
            if (soc_take) begin
                align      <= soc_off;
                start_time <= smp_cnt - TW'(soc_off);
                end_time   <= smp_cnt - TW'(soc_off);
            end else if (asm_push) begin
                end_time <= end_time + TW'(SPP);
            end
        end
    end

    assign busy = (st != ST_IDLE);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!busy && $past(busy)));

    // R3
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_reset |-> (!busy && frame_len == '0));

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && err_reset));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nib_valid |=> ($stable(busy) && !frame_done && !err_reset));

    // R9
    end_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ((end_time - start_time) >= TW'(SPP)));
endmodule

// File: tb/miller_frame_decoder_bench.sv
`timescale 1ns/1ps
module miller_frame_decoder_bench;
    localparam int MAXB = 4;
    localparam int TW   = 16;
    localparam int LW   = $clog2(MAXB + 1);
    localparam logic [3:0] P_X = 4'b0011, P_Y = 4'b0000, P_Z = 4'b1100, P_BAD = 4'b1111;

    typedef struct packed {
        logic [47:0] bits;
        int          nb;
        int          k;
        bit          gappy;
        int          exp_len;
        int          exp_last;
        bit          exp_short;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{48'h1A5,          9,  0, 1'b0, 1, 0, 1'b0},
        '{48'h26,           7,  1, 1'b0, 1, 7, 1'b1},
        '{48'h4193,         18, 2, 1'b1, 2, 0, 1'b0},
        '{48'hB3C,          12, 3, 1'b0, 2, 3, 1'b0},
        '{48'h0,            9,  0, 1'b0, 1, 0, 1'b0},
        '{48'h1FF,          9,  2, 1'b0, 1, 0, 1'b0},
        '{48'h0,            0,  1, 1'b0, 0, 0, 1'b0},
        '{48'h0123456789AB, 45, 0, 1'b0, 4, 0, 1'b0},
        '{48'h5A,           8,  3, 1'b0, 1, 8, 1'b0},
        '{48'hBEEF,         16, 1, 1'b0, 2, 7, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nib_valid = 1'b0;
    logic [3:0] nib = 4'h0;
    logic busy, frame_done, err_reset, short_frame;
    logic [8*MAXB-1:0] frame_data;
    logic [MAXB-1:0] frame_par;
    logic [LW-1:0] frame_len;
    logic [3:0] last_bits;
    logic [TW-1:0] start_time, end_time;

    int checks = 0, failures = 0;
    int done_cnt = 0, err_cnt = 0;
    bit busy_seen = 1'b0;
    bit finished = 1'b0;
    longint gs = 0;
    logic smp_q [0:1023];
    int smp_n = 0;

    always #2 clk = ~clk;

    miller_frame_decoder #(.MAX_BYTES(MAXB), .TW(TW)) u_miller_frame_decoder (
        .clk(clk), .rst_n(rst_n), .nib_valid(nib_valid), .nib(nib),
        .busy(busy), .frame_done(frame_done), .err_reset(err_reset),
        .frame_data(frame_data), .frame_par(frame_par), .frame_len(frame_len),
        .last_bits(last_bits), .short_frame(short_frame),
        .start_time(start_time), .end_time(end_time)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_done) done_cnt++;
            if (err_reset) err_cnt++;
            if (busy) busy_seen = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic add_sym(input logic [3:0] p);
        for (int i = 3; i >= 0; i--) begin
            smp_q[smp_n] = p[i];
            smp_n++;
        end
    endtask

    task automatic add_idle(input int n);
        for (int i = 0; i < n; i++) begin
            smp_q[smp_n] = 1'b0;
            smp_n++;
        end
    endtask

    task automatic encode(input logic [47:0] bits, input int n);
        bit last_x;
        add_sym(P_Z);
        last_x = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (bits[i]) begin
                add_sym(P_X);
                last_x = 1'b1;
            end else begin
                add_sym(last_x ? P_Y : P_Z);
                last_x = 1'b0;
            end
        end
        add_sym(last_x ? P_Y : P_Z);
        add_sym(P_Y);
    endtask

    task automatic feed(input bit gappy);
        while (smp_n % 4 != 0) add_idle(1);
        for (int i = 0; i < smp_n; i += 4) begin
            @(negedge clk);
            nib_valid = 1'b1;
            nib = {smp_q[i], smp_q[i+1], smp_q[i+2], smp_q[i+3]};
            gs += 4;
            if (gappy) begin
                @(negedge clk);
                nib_valid = 1'b0;
                nib = 4'hF;
            end
        end
        @(negedge clk);
        nib_valid = 1'b0;
        nib = 4'h0;
        smp_n = 0;
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        longint fs;
        int d0, e0, q, r;
        logic [8*MAXB-1:0] ed;
        logic [MAXB-1:0] ep;
        d0 = done_cnt;
        e0 = err_cnt;
        busy_seen = 1'b0;
        fs = gs + 8 + v.k;
        add_idle(8 + v.k);
        encode(v.bits, v.nb);
        add_idle(12);
        feed(v.gappy);
        ed = '0;
        ep = '0;
        q = v.nb / 9;
        r = v.nb % 9;
        for (int b = 0; b < MAXB; b++) begin
            if (b < q) begin
                for (int j = 0; j < 8; j++) ed[8*b + j] = v.bits[9*b + j];
                ep[MAXB-1-b] = v.bits[9*b + 8];
            end else if (b == q && r != 0) begin
                for (int j = 0; j < r; j++) ed[8*b + j] = v.bits[9*b + j];
            end
        end
        $display("vector %0d", idx);
        check(done_cnt - d0 == 1, "R5 one frame_done", done_cnt - d0, 1);
        check(err_cnt == e0, "R1 no err_reset on legal stream", err_cnt - e0, 0);
        check(busy_seen, "R2 busy during frame", busy_seen, 1);
        check(!busy, "R5 busy low after end", busy, 0);
        check(frame_len == LW'(v.exp_len), "R10 frame_len", frame_len, v.exp_len);
        check(last_bits == 4'(v.exp_last), "R7 last_bits", last_bits, v.exp_last);
        check(short_frame == v.exp_short, "R8 short_frame", short_frame, v.exp_short);
        check(frame_data == ed, "R7 frame_data", frame_data, ed);
        check(frame_par == ep, "R7 frame_par", frame_par, ep);
        check(start_time == TW'(fs), "R9 start_time", start_time, fs);
        check(end_time == TW'(fs + 4 * (v.nb + 1)), "R9 end_time", end_time, fs + 4 * (v.nb + 1));
    endtask

    task automatic run_err(input logic [3:0] second, input logic [3:0] third,
                           input bit use_third, input string req, input bit exact);
        int d0, e0;
        d0 = done_cnt;
        e0 = err_cnt;
        add_idle(8);
        add_sym(P_Z);
        add_sym(second);
        if (use_third) add_sym(third);
        add_idle(16);
        feed(1'b0);
        if (exact) check(err_cnt - e0 == 1, {req, " err_reset count"}, err_cnt - e0, 1);
        else       check(err_cnt - e0 >= 1, {req, " err_reset seen"}, err_cnt - e0, 1);
        check(done_cnt == d0, {req, " no frame_done"}, done_cnt - d0, 0);
        check(!busy, {req, " unsynchronised after violation"}, busy, 0);
        check(frame_len == '0, {req, " frame_len cleared"}, frame_len, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        // R12 reset state
        check(!busy, "R12 busy", busy, 0);
        check(!frame_done, "R12 frame_done", frame_done, 0);
        check(!err_reset, "R12 err_reset", err_reset, 0);
        check(frame_len == '0, "R12 frame_len", frame_len, 0);
        check(last_bits == '0, "R12 last_bits", last_bits, 0);
        check(!short_frame, "R12 short_frame", short_frame, 0);
        @(negedge clk);
        rst_n = 1'b1;
        gs = 0;
        // table walk: R1 R2 R5 R7 R8 R9 R10, vector 2 with idle cycles for R11
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
        // R3 both halves paused after an X
        run_err(P_X, P_BAD, 1'b1, "R3", 1'b0);
        run_vec(VECS[0], 100);
        // R4 Z straight after X
        run_err(P_X, P_Z, 1'b1, "R4", 1'b0);
        run_vec(VECS[3], 101);
        // R6 Y straight after start period
        run_err(P_Y, P_Y, 1'b0, "R6", 1'b1);
        // R11 a garbage nibble without nib_valid changes nothing
        @(negedge clk);
        nib = 4'b1100;
        repeat (3) @(negedge clk);
        #1;
        check(!busy, "R11 invalid nibble ignored", busy, 0);
        nib = 4'h0;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule